// File: doc/BRIEF.md
# Coherent Line Fetch Read Master

This block pulls whole cache lines out of a processor's coherent accelerator port over an AXI4 read channel. A client hands it a start address and a count of lines. The block then issues one 64-byte INCR burst per line, one after another. It gathers the four 16-byte data beats of each burst into one 512-bit line and offers that line on a valid/ready output. The line carries a flag that tells whether any beat came back with an error response.

The address-channel attributes are fixed at the values a snooping port needs so that the read is looked up in the processor caches. The read is marked write-back cacheable with allocation, it belongs to the inner shareable domain, and it is marked non-secure. If the non-secure marking were missing, the lookup would miss lines that non-secure software had cached, and the read would return stale memory.

A command whose start address is not on a line boundary is taken and dropped locally. It raises an error flag and never reaches the bus. The block keeps only one burst in flight at a time.

Top module: `coh_line_fetch`

## Requirements
- R1: Every read address carries these fixed attributes: burst type INCR (`ar_burst`=2'b01), `ar_len`=3 (four beats), `ar_size`=3'd4 (16 bytes per beat), `ar_cache`=4'hF, `ar_prot`=3'b010 (bit 1 set, meaning non-secure), `ar_user`=2'b01 (inner shareable), and `ar_id`, `ar_lock` and `ar_qos` all zero.
- R2: A command whose address has any of its low six bits set is accepted and produces no address handshake. From the cycle after it is accepted, `cmd_err` reads 1 and stays at 1 until the next command is accepted. Every address the block does issue has its low six bits at zero.
- R3: An aligned command with N lines (N > 0) issues exactly N bursts. The first burst uses the command address, and each later burst uses the previous address plus 64. A command with N = 0 issues nothing.
- R4: At most one burst is outstanding at a time. `ar_valid` stays low from its handshake until the line that burst produced has been handed over on the output.
- R5: Once raised, `ar_valid` stays high with an unchanged `ar_addr` until `ar_ready` is seen.
- R6: `r_ready` is high only while the block is collecting a burst. The beat accepted k-th (counting from 0) appears at bits [128k+127:128k] of `line_data`. `line_valid` rises in the cycle after the beat marked `r_last` is accepted.
- R7: If any beat of a burst has `r_resp` other than 2'b00, `line_err` is 1 for that line. The remaining beats are still accepted up to `r_last`. A following line with only OKAY beats reports `line_err` = 0.
- R8: `line_valid` stays high, with `line_data` and `line_err` unchanged, until `line_ready` is seen.
- R9: After reset, `cmd_ready` is 1 and `ar_valid`, `r_ready`, `line_valid` and `cmd_err` are 0. `cmd_ready` is 1 only while no command is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_addr | input | 40 | Start byte address of the first line |
| cmd_lines | input | 8 | Number of lines to fetch |
| cmd_err | output | 1 | Last accepted command was misaligned |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address accepted |
| ar_addr | output | 40 | Burst start address |
| ar_len | output | 8 | Burst length minus one |
| ar_size | output | 3 | Log2 of bytes per beat |
| ar_burst | output | 2 | Burst type |
| ar_cache | output | 4 | Memory attributes |
| ar_prot | output | 3 | Protection attributes |
| ar_user | output | 2 | Shareability domain |
| ar_id | output | 2 | Transaction ID |
| ar_lock | output | 1 | Exclusive access flag |
| ar_qos | output | 4 | Quality of service |
| r_valid | input | 1 | Read data valid |
| r_ready | output | 1 | Read data accepted |
| r_data | input | 128 | Read data beat |
| r_resp | input | 2 | Beat response |
| r_last | input | 1 | Final beat of the burst |
| line_valid | output | 1 | Assembled line available |
| line_ready | input | 1 | Consumer takes the line |
| line_data | output | 512 | Assembled line |
| line_err | output | 1 | Some beat of this line had an error response |

## Verification
The properties assume a well-behaved read slave. It returns data only for a burst that has been issued, it marks the fourth beat and only that beat with `r_last`, and it never drives `r_valid` outside a burst. The bench's slave model keeps to this rule. It answers each address handshake with exactly four beats, and for some vectors it adds idle cycles between beats and holds `ar_ready` low for a while. Commands are offered only while `cmd_ready` is high and are held for a single cycle.

// File: rtl/coh_fetch_pkg.sv
package coh_fetch_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_OUT  = 2'd3
  } fetch_st_t;

  localparam logic [1:0] BURST_INCR   = 2'b01;
  localparam logic [3:0] CACHE_WBRWA  = 4'hF;
  localparam logic [2:0] PROT_NONSEC  = 3'b010;
  localparam logic [1:0] SHARE_INNER  = 2'b01;
  localparam logic [1:0] RESP_OKAY    = 2'b00;

  // log2 of a power-of-two byte count, as a 3-bit size code
  function automatic logic [2:0] size_code(input int unsigned bytes);
    int unsigned v;
    logic [2:0]  c;
    v = bytes;
    c = 3'd0;
    for (int i = 0; i < 8; i++) begin
      if (v > 1) begin
        v = v >> 1;
        c = c + 3'd1;
      end
    end
    return c;
  endfunction

  // true when the low off_w bits of an address are all zero
  function automatic logic low_bits_clear(input logic [63:0] a, input int unsigned off_w);
    logic [63:0] mask;
    mask = (64'd1 << off_w) - 64'd1;
    return (a & mask) == 64'd0;
  endfunction

endpackage

// File: rtl/clf_attr.sv
module clf_attr
  import coh_fetch_pkg::*;
#(
  parameter int unsigned BEATS  = 4,
  parameter int unsigned DATA_W = 128,
  parameter int unsigned ID_W   = 2,
  parameter int unsigned USER_W = 2
) (
  output logic [7:0]        ar_len,
  output logic [2:0]        ar_size,
  output logic [1:0]        ar_burst,
  output logic [3:0]        ar_cache,
  output logic [2:0]        ar_prot,
  output logic [USER_W-1:0] ar_user,
  output logic [ID_W-1:0]   ar_id,
  output logic              ar_lock,
  output logic [3:0]        ar_qos
);
  localparam int unsigned BEAT_BYTES = DATA_W / 8;

  assign ar_len   = 8'(BEATS - 1);
  assign ar_size  = size_code(BEAT_BYTES);
  assign ar_burst = BURST_INCR;
  assign ar_cache = CACHE_WBRWA;
  assign ar_prot  = PROT_NONSEC;
  assign ar_id    = '0;
  assign ar_lock  = 1'b0;
  assign ar_qos   = 4'd0;

  generate
    if (USER_W > 2) begin : g_user_wide
      assign ar_user = {{(USER_W-2){1'b0}}, SHARE_INNER};
    end else begin : g_user_narrow
      assign ar_user = SHARE_INNER[USER_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/clf_seq.sv
module clf_seq
  import coh_fetch_pkg::*;
#(
  parameter int unsigned ADDR_W     = 40,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned OFF_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [CNT_W-1:0]  cmd_lines,
  input  logic              ar_ready,
  input  logic              last_fire,
  input  logic              line_ready,
  output logic              cmd_ready,
  output logic              cmd_err,
  output logic              ar_valid,
  output logic              r_ready,
  output logic              line_valid,
  output logic [ADDR_W-1:0] ar_addr,
  output logic              cmd_fire,
  output logic              ar_fire,
  output logic              line_fire
);
  fetch_st_t         st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic              err_q;
  logic              aligned;

  assign cmd_ready  = (st_q == ST_IDLE);
  assign ar_valid   = (st_q == ST_ADDR);
  assign r_ready    = (st_q == ST_DATA);
  assign line_valid = (st_q == ST_OUT);
  assign ar_addr    = addr_q;
  assign cmd_err    = err_q;

  assign cmd_fire  = cmd_valid && cmd_ready;
  assign ar_fire   = ar_valid && ar_ready;
  assign line_fire = line_valid && line_ready;
  assign aligned   = low_bits_clear(64'(cmd_addr), OFF_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      left_q <= '0;
      err_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (cmd_fire) begin
            err_q <= !aligned;
            if (aligned && cmd_lines != '0) begin
              addr_q <= cmd_addr;
              left_q <= cmd_lines;
              st_q   <= ST_ADDR;
            end
          end
        end
        ST_ADDR: if (ar_ready) st_q <= ST_DATA;
        ST_DATA: if (last_fire) st_q <= ST_OUT;
        ST_OUT: begin
          if (line_ready) begin
            if (left_q == CNT_W'(1)) begin
              st_q <= ST_IDLE;
            end else begin
              st_q   <= ST_ADDR;
              addr_q <= addr_q + ADDR_W'(LINE_BYTES);
            end
            left_q <= left_q - CNT_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clf_collect.sv
module clf_collect
  import coh_fetch_pkg::*;
#(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned BEATS  = 4,
  parameter int unsigned IDX_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    beat_fire,
  input  logic [DATA_W-1:0]       r_data,
  input  logic [1:0]              r_resp,
  output logic [BEATS*DATA_W-1:0] line_data,
  output logic                    line_err
);
  logic [IDX_W-1:0] idx_q;
  logic             err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      err_q <= 1'b0;
    end else if (start) begin
      idx_q <= '0;
      err_q <= 1'b0;
    end else if (beat_fire) begin
      idx_q <= idx_q + IDX_W'(1);
      if (r_resp != RESP_OKAY) err_q <= 1'b1;
    end
  end

  assign line_err = err_q;

  generate
    for (genvar g = 0; g < BEATS; g++) begin : g_slot
      logic [DATA_W-1:0] slot_q;
      always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else if (beat_fire && idx_q == IDX_W'(g)) slot_q <= r_data;
      end
      assign line_data[g*DATA_W +: DATA_W] = slot_q;
    end
  endgenerate
endmodule

// File: rtl/coh_line_fetch.sv
module coh_line_fetch
  import coh_fetch_pkg::*;
#(
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned DATA_W = 128,
  parameter int unsigned BEATS  = 4,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned ID_W   = 2,
  parameter int unsigned USER_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic [ADDR_W-1:0]       cmd_addr,
  input  logic [CNT_W-1:0]        cmd_lines,
  output logic                    cmd_err,
  output logic                    ar_valid,
  input  logic                    ar_ready,
  output logic [ADDR_W-1:0]       ar_addr,
  output logic [7:0]              ar_len,
  output logic [2:0]              ar_size,
  output logic [1:0]              ar_burst,
  output logic [3:0]              ar_cache,
  output logic [2:0]              ar_prot,
  output logic [USER_W-1:0]       ar_user,
  output logic [ID_W-1:0]         ar_id,
  output logic                    ar_lock,
  output logic [3:0]              ar_qos,
  input  logic                    r_valid,
  output logic                    r_ready,
  input  logic [DATA_W-1:0]       r_data,
  input  logic [1:0]              r_resp,
  input  logic                    r_last,
  output logic                    line_valid,
  input  logic                    line_ready,
  output logic [BEATS*DATA_W-1:0] line_data,
  output logic                    line_err
);
  localparam int unsigned LINE_BYTES = BEATS * DATA_W / 8;
  localparam int unsigned OFF_W      = $clog2(LINE_BYTES);
  localparam int unsigned IDX_W      = (BEATS > 1) ? $clog2(BEATS) : 1;

  // named events for the checker
  logic cmd_fire;
  logic ar_fire;
  logic beat_fire;
  logic last_fire;
  logic line_fire;

  assign beat_fire = r_valid && r_ready;
  assign last_fire = beat_fire && r_last;

  clf_seq #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LINE_BYTES(LINE_BYTES), .OFF_W(OFF_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_lines(cmd_lines),
    .ar_ready(ar_ready), .last_fire(last_fire), .line_ready(line_ready),
    .cmd_ready(cmd_ready), .cmd_err(cmd_err), .ar_valid(ar_valid),
    .r_ready(r_ready), .line_valid(line_valid), .ar_addr(ar_addr),
    .cmd_fire(cmd_fire), .ar_fire(ar_fire), .line_fire(line_fire)
  );

  clf_collect #(
    .DATA_W(DATA_W), .BEATS(BEATS), .IDX_W(IDX_W)
  ) u_collect (
    .clk(clk), .rst_n(rst_n),
    .start(ar_fire), .beat_fire(beat_fire),
    .r_data(r_data), .r_resp(r_resp),
    .line_data(line_data), .line_err(line_err)
  );

  clf_attr #(
    .BEATS(BEATS), .DATA_W(DATA_W), .ID_W(ID_W), .USER_W(USER_W)
  ) u_attr (
    .ar_len(ar_len), .ar_size(ar_size), .ar_burst(ar_burst),
    .ar_cache(ar_cache), .ar_prot(ar_prot), .ar_user(ar_user),
    .ar_id(ar_id), .ar_lock(ar_lock), .ar_qos(ar_qos)
  );
endmodule

// File: rtl/clf_checker.sv
module clf_checker #(
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned LINE_W = 512,
  parameter int unsigned OFF_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_fire,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              cmd_ready,
  input logic              cmd_err,
  input logic              ar_valid,
  input logic              ar_ready,
  input logic              ar_fire,
  input logic [ADDR_W-1:0] ar_addr,
  input logic              r_ready,
  input logic              beat_fire,
  input logic              last_fire,
  input logic [1:0]        r_resp,
  input logic              line_valid,
  input logic              line_ready,
  input logic [LINE_W-1:0] line_data,
  input logic              line_err
);
  logic misaligned;
  logic [ADDR_W-1:0] off_mask;
  assign off_mask   = (ADDR_W'(1) << OFF_W) - ADDR_W'(1);
  assign misaligned = (cmd_addr & off_mask) != '0;

  AST_AR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid |-> (ar_addr & off_mask) == '0); // R2
  AST_MISALIGN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && misaligned |=> !ar_valid && cmd_err); // R2
  AST_ONE_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    ar_fire |=> !ar_valid); // R4
  AST_AR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid |-> !r_ready && !line_valid); // R4
  AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid && !ar_ready |=> ar_valid && $stable(ar_addr)); // R5
  AST_LAST_TO_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire |=> line_valid); // R6
  AST_ERR_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire && r_resp != 2'b00 |=> line_valid && line_err); // R7
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid && !line_ready |=> line_valid && $stable(line_data) && $stable(line_err)); // R8
  AST_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !ar_valid && !r_ready && !line_valid); // R9
  AST_NO_STRAY_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire |-> !cmd_ready); // R6
endmodule

bind coh_line_fetch clf_checker #(
  .ADDR_W(ADDR_W), .LINE_W(BEATS*DATA_W), .OFF_W(OFF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_fire(cmd_fire), .cmd_addr(cmd_addr),
  .cmd_ready(cmd_ready), .cmd_err(cmd_err), .ar_valid(ar_valid),
  .ar_ready(ar_ready), .ar_fire(ar_fire), .ar_addr(ar_addr),
  .r_ready(r_ready), .beat_fire(beat_fire), .last_fire(last_fire),
  .r_resp(r_resp), .line_valid(line_valid), .line_ready(line_ready),
  .line_data(line_data), .line_err(line_err)
);

// File: tb/sim_coh_line_fetch.sv
`timescale 1ns/1ps
module sim_coh_line_fetch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic         cmd_valid = 1'b0, cmd_ready, cmd_err;
  logic [39:0]  cmd_addr = '0;
  logic [7:0]   cmd_lines = '0;
  logic         ar_valid, ar_ready = 1'b0;
  logic [39:0]  ar_addr;
  logic [7:0]   ar_len;
  logic [2:0]   ar_size, ar_prot;
  logic [1:0]   ar_burst, ar_user, ar_id;
  logic [3:0]   ar_cache, ar_qos;
  logic         ar_lock;
  logic         r_valid = 1'b0, r_ready, r_last = 1'b0;
  logic [127:0] r_data = '0;
  logic [1:0]   r_resp = 2'b00;
  logic         line_valid, line_ready = 1'b0, line_err;
  logic [511:0] line_data;

  int n_chk = 0;
  int n_bad = 0;

  coh_line_fetch u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_lines(cmd_lines), .cmd_err(cmd_err),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr),
    .ar_len(ar_len), .ar_size(ar_size), .ar_burst(ar_burst),
    .ar_cache(ar_cache), .ar_prot(ar_prot), .ar_user(ar_user),
    .ar_id(ar_id), .ar_lock(ar_lock), .ar_qos(ar_qos),
    .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data),
    .r_resp(r_resp), .r_last(r_last), .line_valid(line_valid),
    .line_ready(line_ready), .line_data(line_data), .line_err(line_err)
  );

  // vector table: address, lines, bad line index (FF = none), bad beat, bad code, ar wait, beat gap
  localparam int NV = 5;
  localparam logic [39:0] V_ADDR [NV] = '{40'h00_8000_0000, 40'h10_0000_0040,
                                          40'h00_0000_0FC0, 40'hFF_FFFF_FF80,
                                          40'h00_1234_5600};
  localparam logic [7:0]  V_LINES[NV] = '{8'd1, 8'd3, 8'd2, 8'd2, 8'd4};
  localparam logic [7:0]  V_BADL [NV] = '{8'hFF, 8'd1, 8'd0, 8'hFF, 8'd3};
  localparam logic [1:0]  V_BADB [NV] = '{2'd0, 2'd2, 2'd0, 2'd0, 2'd3};
  localparam logic [1:0]  V_CODE [NV] = '{2'b00, 2'b10, 2'b11, 2'b00, 2'b10};
  localparam int          V_WAIT [NV] = '{0, 2, 1, 3, 0};
  localparam bit          V_GAP  [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

  function automatic logic [127:0] pat(input logic [39:0] a, input int b);
    return {a[31:0] + 32'(b), ~a[31:0], 32'hC0DE_0000 | 32'(b), a[39:8]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [39:0] a, input logic [7:0] n);
    chk(cmd_ready, "R9 cmd_ready before command", 512'(cmd_ready), 512'(1));
    cmd_valid = 1'b1; cmd_addr = a; cmd_lines = n;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic serve_line(input logic [39:0] a, input int wt, input bit gap,
                            input int bad_b, input logic [1:0] code, input int hold);
    int t;
    logic [511:0] exp;
    logic [8:0] attrs;
    t = 0;
    while (!ar_valid && t < 50) begin @(negedge clk); t++; end
    chk(ar_valid, "R3 burst issued", 512'(ar_valid), 512'(1));
    chk(ar_addr == a, "R3 burst address", 512'(ar_addr), 512'(a));
    attrs = {ar_burst == 2'b01, ar_len == 8'd3, ar_size == 3'd4, ar_cache == 4'hF,
             ar_prot == 3'b010, ar_user == 2'b01, ar_id == 2'd0, !ar_lock, ar_qos == 4'd0};
    chk(&attrs, "R1 address attributes", 512'(attrs), 512'(9'h1FF));
    for (int w = 0; w < wt; w++) begin
      @(negedge clk);
      chk(ar_valid && ar_addr == a, "R5 address held while stalled", 512'(ar_addr), 512'(a));
    end
    ar_ready = 1'b1;
    @(negedge clk);
    ar_ready = 1'b0;
    chk(!ar_valid, "R4 no second burst in flight", 512'(ar_valid), 512'(0));
    for (int b = 0; b < 4; b++) begin
      if (gap && b == 2) begin
        r_valid = 1'b0;
        @(negedge clk);
      end
      r_valid = 1'b1; r_data = pat(a, b); r_last = (b == 3);
      r_resp = (b == bad_b) ? code : 2'b00;
      chk(r_ready, "R6 r_ready while collecting", 512'(r_ready), 512'(1));
      exp[128*b +: 128] = pat(a, b);
      @(negedge clk);
    end
    r_valid = 1'b0; r_last = 1'b0; r_resp = 2'b00;
    chk(line_valid, "R6 line offered after last beat", 512'(line_valid), 512'(1));
    chk(line_data == exp, "R6 line data placement", line_data, exp);
    chk(line_err == (bad_b < 4 && code != 2'b00), "R7 line error flag",
        512'(line_err), 512'(bad_b < 4 && code != 2'b00));
    chk(!ar_valid && !r_ready, "R4 idle bus while line waits", 512'({ar_valid, r_ready}), 512'(0));
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(line_valid && line_data == exp, "R8 line held until taken", line_data, exp);
    end
    line_ready = 1'b1;
    @(negedge clk);
    line_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(cmd_ready && !ar_valid && !r_ready && !line_valid && !cmd_err, "R9 reset state",
        512'({cmd_ready, ar_valid, r_ready, line_valid, cmd_err}), 512'(5'b10000));

    // vector table
    for (int v = 0; v < NV; v++) begin
      send_cmd(V_ADDR[v], V_LINES[v]);
      chk(!cmd_ready, "R9 busy after command", 512'(cmd_ready), 512'(0));
      for (int i = 0; i < V_LINES[v]; i++) begin
        serve_line(V_ADDR[v] + 40'(64 * i), V_WAIT[v], V_GAP[v],
                   (8'(i) == V_BADL[v]) ? int'(V_BADB[v]) : 4, V_CODE[v], (i == 0) ? 1 : 0);
      end
      for (int k = 0; k < 3; k++) begin
        chk(!ar_valid && cmd_ready, "R3 nothing beyond requested lines",
            512'({ar_valid, cmd_ready}), 512'(2'b01));
        @(negedge clk);
      end
    end

    // R2 misaligned commands
    send_cmd(40'h00_0000_1020, 8'd2);
    chk(cmd_err, "R2 error flag after misaligned command", 512'(cmd_err), 512'(1));
    for (int k = 0; k < 4; k++) begin
      chk(!ar_valid && cmd_ready && cmd_err, "R2 misaligned command not issued",
          512'({ar_valid, cmd_ready, cmd_err}), 512'(3'b011));
      @(negedge clk);
    end
    send_cmd(40'h00_0000_2001, 8'd1);
    chk(cmd_err && !ar_valid, "R2 low bit misaligned", 512'({cmd_err, ar_valid}), 512'(2'b10));
    @(negedge clk);
    // R3 zero lines, also clears the error flag
    send_cmd(40'h00_0000_3000, 8'd0);
    chk(!cmd_err, "R2 flag clears on next command", 512'(cmd_err), 512'(0));
    for (int k = 0; k < 4; k++) begin
      chk(!ar_valid && cmd_ready, "R3 zero-line command issues nothing",
          512'({ar_valid, cmd_ready}), 512'(2'b01));
      @(negedge clk);
    end
    // R7 error line followed by clean line, long hold on the output
    send_cmd(40'h00_0000_4000, 8'd2);
    serve_line(40'h00_0000_4000, 1, 1'b0, 1, 2'b10, 3);
    serve_line(40'h00_0000_4040, 0, 1'b0, 4, 2'b00, 2);
    @(negedge clk);
    chk(cmd_ready && !cmd_err, "R9 idle after run", 512'({cmd_ready, cmd_err}), 512'(2'b10));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule